// File: doc/BRIEF.md
# Trap and Interrupt Priority Arbiter

This block decides which pending event a processor services at an instruction boundary. Three kinds of candidate compete. Internal trap requests are held in a pending bitmask. Programmed (software) interrupt requests are held in a small request register. External bus interrupts arrive as one request line and one device-supplied vector per priority level. Internal traps always win. When no trap is pending, levels are scanned from the highest level down to one above the current processor priority. At each level a programmed request is considered before a bus request.

The core pulses the evaluate strobe at each instruction boundary. One cycle later the arbiter raises a one-cycle take strobe and presents the vector address. In the same edge it either clears the serviced trap bit or pulses an acknowledge to the chosen bus level. The stack pushes are done by a separate sequencer, which uses the vector.

The arbiter also tracks a wait-for-interrupt condition. In that condition it evaluates every cycle. Only a winning bus interrupt takes the processor out of the wait and back to running.

The controller has three states:
- RUN: normal execution.
- WAIT: halted until an interrupt arrives.
- TAKE: the one-cycle vectoring cycle.

It has five transitions:
- RUN→TAKE: evaluate is high and an event is pending.
- RUN→WAIT: the wait request is high and nothing is taken.
- WAIT→TAKE: a bus interrupt wins.
- TAKE→RUN: always.
- WAIT→WAIT: any other winner, or none.

Top module: `trap_irq_arbiter`

## Requirements
- R1: After reset the following are all zero: `take_o`, `bus_ack_o`, `trap_pend_o`, `pirq_o` and `waiting_o`, and the controller is in RUN.
- R2: When any trap bit is pending, the highest-numbered pending bit wins over every interrupt. The vector is 0x0010 + 4 × bit index, and `bus_ack_o` stays zero.
- R3: A trap request sets its pending bit one cycle after the request is seen. The serviced bit is cleared in the same edge that raises `take_o`, and all other pending bits are kept. A request for the serviced bit that arrives in that same cycle keeps the bit set.
- R4: With no trap pending, only levels strictly above `cur_pri_i` are eligible. Among them the highest level with any request wins. Level L's bus request is bit L−1 of `bus_req_i`, and its vector is `bus_vec_i[16(L−1) +: 16]`.
- R5: If the winning level has its programmed request bit set (bit 8+L of `pirq_o`), the vector is 0x00A0 and no acknowledge is given, even if that level also has a bus request.
- R6: If the winning level has only a bus request, the vector is that level's device vector. `bus_ack_o` bit L−1 pulses alone for exactly the take cycle.
- R7: `take_o` rises on the clock edge after `eval_i` is seen with an event pending and lasts exactly one cycle. An evaluate seen during the take cycle is ignored. An evaluate with no eligible event gives no take.
- R8: A write stores `pirq_wdata_i[15:9]` as the request bits. `pirq_o[8:0]` always reads zero. Taking a programmed interrupt does not change the register.
- R9: `wait_i` in RUN moves the controller to WAIT, where `waiting_o` is 1. In WAIT, a pending trap, a programmed request or a masked bus request does not take anything. An eligible bus winner takes at once and the controller returns to RUN.
- R10: In RUN, no take happens without `eval_i`, even when events are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Instruction-boundary evaluate strobe |
| wait_i | input | 1 | Processor enters wait-for-interrupt |
| cur_pri_i | input | 3 | Current processor priority (0..7) |
| trap_set_i | input | NUM_TRAPS | Trap request pulses, one bit per cause |
| pirq_wr_i | input | 1 | Programmed-request register write enable |
| pirq_wdata_i | input | 16 | Programmed-request register write data |
| bus_req_i | input | NUM_LEVELS | Bus interrupt request, bit L−1 for level L |
| bus_vec_i | input | NUM_LEVELS×16 | Device vectors, one 16-bit slice per level |
| take_o | output | 1 | One-cycle take-event strobe |
| vector_o | output | 16 | Vector address of the taken event |
| bus_ack_o | output | NUM_LEVELS | One-cycle acknowledge to the chosen bus level |
| trap_pend_o | output | NUM_TRAPS | Pending trap bitmask |
| pirq_o | output | 16 | Programmed-request register contents |
| waiting_o | output | 1 | Controller is in WAIT |

## Verification
The checker watches several properties on every cycle:
- the take strobe is a single-cycle pulse;
- the acknowledge is one-hot and appears only with a take;
- a trap take removes exactly one pending bit and never acknowledges a bus level;
- no take appears without an evaluate outside WAIT;
- a wake from WAIT always carries a bus acknowledge;
- the programmed-request register holds between writes.

The correctness of the choice itself can only be shown by the bench's sweeps: the exact vector, the level picked under each priority mask, the ordering of programmed over bus requests, and the order in which several traps are serviced. Those sweeps cover all request masks at every priority.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_TAKE = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TRAP = 2'd1,
        SRC_PIRQ = 2'd2,
        SRC_BUS  = 2'd3
    } arb_src_e;

endpackage

// File: rtl/arb_trap_pending.sv
module arb_trap_pending #(
    parameter int NUM_TRAPS = 8,
    localparam int TIDX_W = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TRAPS-1:0] set_i,
    input  logic [NUM_TRAPS-1:0] clr_i,
    output logic [NUM_TRAPS-1:0] pend_o,
    output logic                 hit_o,
    output logic [TIDX_W-1:0]    idx_o
);

    logic [NUM_TRAPS-1:0] pend_q;

    // a fresh request for the bit being cleared keeps it armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | set_i;
        end
    end

    // highest index wins: later loop iterations overwrite earlier ones
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM_TRAPS; i++) begin
            if (pend_q[i]) begin
                hit_o = 1'b1;
                idx_o = TIDX_W'(i);
            end
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/arb_level_scan.sv
module arb_level_scan #(
    parameter int NUM_LEVELS  = 7,
    parameter int VEC_W       = 16,
    parameter int PIRQ_VECTOR = 'hA0,
    localparam int PRI_W = $clog2(NUM_LEVELS + 1),
    localparam int LIDX_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
    input  logic [PRI_W-1:0]            cur_pri_i,
    input  logic [NUM_LEVELS-1:0]       pirq_i,
    input  logic [NUM_LEVELS-1:0]       bus_req_i,
    input  logic [NUM_LEVELS*VEC_W-1:0] bus_vec_i,
    output logic                        hit_o,
    output logic                        is_pirq_o,
    output logic [VEC_W-1:0]            vec_o,
    output logic [NUM_LEVELS-1:0]       ack_o
);

    logic [NUM_LEVELS-1:0] eligible;
    logic [VEC_W-1:0]      vec_arr [NUM_LEVELS];
    logic [LIDX_W-1:0]     sel;

    // entry g serves level g+1; it is eligible only strictly above the priority
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        assign eligible[g] = (PRI_W'(g + 1) > cur_pri_i);
        assign vec_arr[g]  = bus_vec_i[g*VEC_W +: VEC_W];
    end

    // scan upward so the highest eligible requesting level remains selected
    always_comb begin
        hit_o = 1'b0;
        sel   = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (eligible[i] && (pirq_i[i] || bus_req_i[i])) begin
                hit_o = 1'b1;
                sel   = LIDX_W'(i);
            end
        end
    end

    always_comb begin
        is_pirq_o = hit_o && pirq_i[sel];
        ack_o     = '0;
        if (is_pirq_o) begin
            vec_o = VEC_W'(PIRQ_VECTOR);
        end else begin
            vec_o = vec_arr[sel];
            if (hit_o) begin
                ack_o[sel] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
#(
    parameter int NUM_LEVELS = 7,
    parameter int VEC_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  eval_i,
    input  logic                  wait_i,
    input  arb_src_e              dec_src_i,
    input  logic [VEC_W-1:0]      dec_vec_i,
    input  logic [NUM_LEVELS-1:0] dec_ack_i,
    output logic                  take_en_o,
    output logic                  take_o,
    output logic [VEC_W-1:0]      vector_o,
    output logic [NUM_LEVELS-1:0] ack_o,
    output logic                  waiting_o
);

    arb_state_e state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (eval_i && (dec_src_i != SRC_NONE)) begin
                    state_n = ST_TAKE;
                end else if (wait_i) begin
                    state_n = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (dec_src_i == SRC_BUS) begin
                    state_n = ST_TAKE;
                end
            end
            ST_TAKE: begin
                state_n = ST_RUN;
            end
            default: begin
                state_n = ST_RUN;
            end
        endcase
    end

    assign take_en_o = (state_n == ST_TAKE);
    assign waiting_o = (state_q == ST_WAIT);

    // output registers: strobe and acknowledge for one cycle, vector held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o   <= 1'b0;
            vector_o <= '0;
            ack_o    <= '0;
        end else begin
            take_o <= take_en_o;
            ack_o  <= take_en_o ? dec_ack_i : '0;
            if (take_en_o) begin
                vector_o <= dec_vec_i;
            end
        end
    end

endmodule

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_TRAPS     = 8,
    parameter int NUM_LEVELS    = 7,
    parameter int VEC_W         = 16,
    parameter int REG_W         = 16,
    parameter int PIRQ_VECTOR   = 'hA0,
    parameter int TRAP_VEC_BASE = 'h10,
    parameter int TRAP_VEC_STEP = 4,
    localparam int PRI_W    = $clog2(NUM_LEVELS + 1),
    localparam int TIDX_W   = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1,
    localparam int PIRQ_LSB = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        eval_i,
    input  logic                        wait_i,
    input  logic [PRI_W-1:0]            cur_pri_i,
    input  logic [NUM_TRAPS-1:0]        trap_set_i,
    input  logic                        pirq_wr_i,
    input  logic [REG_W-1:0]            pirq_wdata_i,
    input  logic [NUM_LEVELS-1:0]       bus_req_i,
    input  logic [NUM_LEVELS*VEC_W-1:0] bus_vec_i,
    output logic                        take_o,
    output logic [VEC_W-1:0]            vector_o,
    output logic [NUM_LEVELS-1:0]       bus_ack_o,
    output logic [NUM_TRAPS-1:0]        trap_pend_o,
    output logic [REG_W-1:0]            pirq_o,
    output logic                        waiting_o
);

    logic [NUM_LEVELS-1:0] pirq_q;
    logic [NUM_TRAPS-1:0]  trap_clr;
    logic                  trap_hit;
    logic [TIDX_W-1:0]     trap_idx;
    logic                  lvl_hit;
    logic                  lvl_is_pirq;
    logic [VEC_W-1:0]      lvl_vec;
    logic [NUM_LEVELS-1:0] lvl_ack;
    arb_src_e              dec_src;
    logic [VEC_W-1:0]      dec_vec;
    logic [NUM_LEVELS-1:0] dec_ack;
    logic                  take_en;

    // programmed request register: one bit per level, cleared only by writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pirq_q <= '0;
        end else if (pirq_wr_i) begin
            pirq_q <= pirq_wdata_i[PIRQ_LSB +: NUM_LEVELS];
        end
    end

    assign pirq_o = REG_W'(pirq_q) << PIRQ_LSB;

    arb_trap_pending #(
        .NUM_TRAPS (NUM_TRAPS)
    ) u_traps (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (trap_set_i),
        .clr_i  (trap_clr),
        .pend_o (trap_pend_o),
        .hit_o  (trap_hit),
        .idx_o  (trap_idx)
    );

    arb_level_scan #(
        .NUM_LEVELS  (NUM_LEVELS),
        .VEC_W       (VEC_W),
        .PIRQ_VECTOR (PIRQ_VECTOR)
    ) u_scan (
        .cur_pri_i (cur_pri_i),
        .pirq_i    (pirq_q),
        .bus_req_i (bus_req_i),
        .bus_vec_i (bus_vec_i),
        .hit_o     (lvl_hit),
        .is_pirq_o (lvl_is_pirq),
        .vec_o     (lvl_vec),
        .ack_o     (lvl_ack)
    );

    // traps outrank every interrupt level
    always_comb begin
        dec_src = SRC_NONE;
        dec_vec = lvl_vec;
        dec_ack = '0;
        if (trap_hit) begin
            dec_src = SRC_TRAP;
            dec_vec = VEC_W'(TRAP_VEC_BASE + TRAP_VEC_STEP * int'(trap_idx));
        end else if (lvl_hit) begin
            dec_src = lvl_is_pirq ? SRC_PIRQ : SRC_BUS;
            dec_ack = lvl_ack;
        end
    end

    assign trap_clr = (take_en && (dec_src == SRC_TRAP))
                      ? (NUM_TRAPS'(1) << trap_idx) : '0;

    arb_fsm #(
        .NUM_LEVELS (NUM_LEVELS),
        .VEC_W      (VEC_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_i    (eval_i),
        .wait_i    (wait_i),
        .dec_src_i (dec_src),
        .dec_vec_i (dec_vec),
        .dec_ack_i (dec_ack),
        .take_en_o (take_en),
        .take_o    (take_o),
        .vector_o  (vector_o),
        .ack_o     (bus_ack_o),
        .waiting_o (waiting_o)
    );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int NUM_TRAPS  = 8,
    parameter int NUM_LEVELS = 7,
    parameter int REG_W      = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  eval_i,
    input logic [NUM_TRAPS-1:0]  trap_set_i,
    input logic                  pirq_wr_i,
    input logic                  take_o,
    input logic [NUM_LEVELS-1:0] bus_ack_o,
    input logic [NUM_TRAPS-1:0]  trap_pend_o,
    input logic [REG_W-1:0]      pirq_o,
    input logic                  waiting_o
);

    // R7
    take_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R6
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_ack_o));

    // R6
    ack_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack_o != '0) |-> take_o);

    // R2
    trap_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ($past(trap_pend_o) != '0)) |-> (bus_ack_o == '0));

    // R3
    trap_drop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && ($past(trap_pend_o) != '0) && ($past(trap_set_i) == '0))
        |-> ($countones(trap_pend_o) == $countones($past(trap_pend_o)) - 1));

    // R10
    no_eval_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(eval_i) && !$past(waiting_o)) |-> !take_o);

    // R9
    wake_by_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(waiting_o)) |-> (bus_ack_o != '0));

    // R8
    pirq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pirq_wr_i) |-> $stable(pirq_o));

    // R8
    pirq_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pirq_o[8:0] == '0);

endmodule

bind trap_irq_arbiter arb_checker #(
    .NUM_TRAPS  (NUM_TRAPS),
    .NUM_LEVELS (NUM_LEVELS),
    .REG_W      (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_i      (eval_i),
    .trap_set_i  (trap_set_i),
    .pirq_wr_i   (pirq_wr_i),
    .take_o      (take_o),
    .bus_ack_o   (bus_ack_o),
    .trap_pend_o (trap_pend_o),
    .pirq_o      (pirq_o),
    .waiting_o   (waiting_o)
);

// File: tb/trap_irq_arbiter_test.sv
`timescale 1ns/1ps
module trap_irq_arbiter_test;

    localparam int NT = 8;
    localparam int NL = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          eval_i = 1'b0;
    logic          wait_i = 1'b0;
    logic [2:0]    cur_pri_i = '0;
    logic [NT-1:0] trap_set_i = '0;
    logic          pirq_wr_i = 1'b0;
    logic [15:0]   pirq_wdata_i = '0;
    logic [NL-1:0] bus_req_i = '0;
    logic [NL*16-1:0] bus_vec_i;
    logic          take_o;
    logic [15:0]   vector_o;
    logic [NL-1:0] bus_ack_o;
    logic [NT-1:0] trap_pend_o;
    logic [15:0]   pirq_o;
    logic          waiting_o;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    trap_irq_arbiter uut (
        .clk (clk), .rst_n (rst_n), .eval_i (eval_i), .wait_i (wait_i),
        .cur_pri_i (cur_pri_i), .trap_set_i (trap_set_i),
        .pirq_wr_i (pirq_wr_i), .pirq_wdata_i (pirq_wdata_i),
        .bus_req_i (bus_req_i), .bus_vec_i (bus_vec_i),
        .take_o (take_o), .vector_o (vector_o), .bus_ack_o (bus_ack_o),
        .trap_pend_o (trap_pend_o), .pirq_o (pirq_o), .waiting_o (waiting_o)
    );

    function automatic logic [15:0] dev_vec(input int lvl);
        return 16'(16'h0200 + lvl * 12);
    endfunction

    function automatic logic [15:0] trap_vec(input int idx);
        return 16'(16'h0010 + 4 * idx);
    endfunction

    initial begin
        for (int l = 1; l <= NL; l++) begin
            bus_vec_i[(l-1)*16 +: 16] = dev_vec(l);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_inputs(input int pri, input logic [6:0] pm, input logic [6:0] bm);
        @(negedge clk);
        cur_pri_i    = 3'(pri);
        bus_req_i    = bm;
        pirq_wr_i    = 1'b1;
        pirq_wdata_i = {pm, 9'h1FF};
        @(negedge clk);
        pirq_wr_i    = 1'b0;
    endtask

    // evaluate once and compare against a level scan done here
    task automatic do_eval(input int pri, input logic [6:0] pm, input logic [6:0] bm);
        int lvl;
        logic [15:0] ev;
        logic [6:0]  ea;
        set_inputs(pri, pm, bm);
        lvl = 0;
        for (int l = 7; l > pri; l--) begin
            if (lvl == 0 && (pm[l-1] || bm[l-1])) lvl = l;
        end
        ea = '0;
        ev = '0;
        if (lvl != 0) begin
            if (pm[lvl-1]) ev = 16'h00A0;
            else begin
                ev = dev_vec(lvl);
                ea[lvl-1] = 1'b1;
            end
        end
        @(negedge clk);
        eval_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0;
        // R4 R7 take only when an eligible level requests
        check(take_o == (lvl != 0), "R4", int'(take_o), int'(lvl != 0));
        if (lvl != 0) begin
            // R5 R6 vector and acknowledge of the winning level
            check(vector_o == ev, pm[lvl-1] ? "R5" : "R6", int'(vector_o), int'(ev));
            check(bus_ack_o == ea, "R6", int'(bus_ack_o), int'(ea));
        end
        @(negedge clk);
        // R7 strobe lasts a single cycle
        check(take_o == 1'b0 && bus_ack_o == '0, "R7", int'(take_o), 0);
        // R8 register unchanged by the take
        check(pirq_o == {pm, 9'h000}, "R8", int'(pirq_o), int'({pm, 9'h000}));
    endtask

    task automatic trap_take(input int idx, input logic [NT-1:0] exp_pend);
        @(negedge clk);
        eval_i = 1'b1;
        @(negedge clk);
        eval_i = 1'b0;
        // R2 highest pending trap beats pending interrupts
        check(take_o && vector_o == trap_vec(idx) && bus_ack_o == '0, "R2",
              int'(vector_o), int'(trap_vec(idx)));
        // R3 only the serviced bit cleared
        check(trap_pend_o == exp_pend, "R3", int'(trap_pend_o), int'(exp_pend));
        @(negedge clk);
    endtask

    initial begin
        #(8ns * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(take_o == 0 && bus_ack_o == 0 && waiting_o == 0, "R1", int'(take_o), 0);
        check(trap_pend_o == 0 && pirq_o == 0, "R1", int'(trap_pend_o), 0);

        // R8 only the level bits are stored
        @(negedge clk);
        pirq_wr_i = 1'b1; pirq_wdata_i = 16'hFFFF;
        @(negedge clk);
        pirq_wr_i = 1'b0;
        check(pirq_o == 16'hFE00, "R8", int'(pirq_o), 'hFE00);

        // R10 pending events without evaluate give no take
        bus_req_i = 7'h7F;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(take_o == 1'b0, "R10", int'(take_o), 0);
        end

        // R4 R5 R6 sweeps over every mask at every priority
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 128; m++) do_eval(p, 7'(m), 7'h00);
            for (int m = 0; m < 128; m++) do_eval(p, 7'h00, 7'(m));
            for (int k = 0; k < 24; k++) do_eval(p, 7'((k * 37 + 11) % 128), 7'((k * 53 + 5) % 128));
        end

        // R2 R3 trap ordering with interrupts pending
        set_inputs(0, 7'h7F, 7'h7F);
        @(negedge clk);
        trap_set_i = 8'hA5;
        @(negedge clk);
        trap_set_i = '0;
        check(trap_pend_o == 8'hA5, "R3", int'(trap_pend_o), 'hA5);
        trap_take(7, 8'h25);
        trap_take(5, 8'h05);

        // R7 evaluate held through the take cycle is ignored there
        @(negedge clk);
        eval_i = 1'b1;
        @(negedge clk);
        check(take_o == 1'b1 && vector_o == trap_vec(2), "R7", int'(vector_o), int'(trap_vec(2)));
        @(negedge clk);
        eval_i = 1'b0;
        check(take_o == 1'b0 && trap_pend_o == 8'h01, "R7", int'(trap_pend_o), 1);
        @(negedge clk);

        // R3 concurrent request keeps the serviced bit, other requests add
        @(negedge clk);
        eval_i = 1'b1; trap_set_i = 8'h09;
        @(negedge clk);
        eval_i = 1'b0; trap_set_i = '0;
        check(take_o && vector_o == trap_vec(0), "R3", int'(vector_o), int'(trap_vec(0)));
        check(trap_pend_o == 8'h09, "R3", int'(trap_pend_o), 'h09);
        @(negedge clk);
        trap_take(3, 8'h01);
        trap_take(0, 8'h00);

        // R9 wait: only an eligible bus winner wakes the processor
        set_inputs(3, 7'h00, 7'h00);
        @(negedge clk);
        wait_i = 1'b1;
        @(negedge clk);
        wait_i = 1'b0;
        check(waiting_o == 1'b1, "R9", int'(waiting_o), 1);
        set_inputs(3, 7'h40, 7'h00);
        repeat (3) @(negedge clk);
        check(waiting_o == 1'b1 && take_o == 1'b0, "R9", int'(take_o), 0);
        set_inputs(3, 7'h40, 7'h1F);
        repeat (3) @(negedge clk);
        check(waiting_o == 1'b1 && take_o == 1'b0, "R9", int'(take_o), 0);
        set_inputs(3, 7'h00, 7'h00);
        bus_req_i = 7'h17;
        @(negedge clk);
        check(take_o == 1'b1 && vector_o == dev_vec(5) && bus_ack_o == 7'h10 && waiting_o == 1'b0,
              "R9", int'(vector_o), int'(dev_vec(5)));
        bus_req_i = '0;
        @(negedge clk);
        check(take_o == 1'b0 && waiting_o == 1'b0, "R9", int'(waiting_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule